// File: doc/BRIEF.md
# SPI Word Packing FIFO Interface

This block sits between a 32-bit register bus and the byte-serial shift engine of an SPI master. Software pushes 32-bit words into a small transmit queue and pops 32-bit words from a small receive queue. The block breaks each transmit word into one, two or four bytes for the engine. It also gathers the bytes the engine receives back into whole words. The word width follows a programmed bits-per-word value.

Transmit words are aligned to the top of the 32-bit word, and the engine takes bytes starting from bits [31:24]. Receive words are right-justified, with the first byte received placed highest. The block counts the words that go out and the words that come in against two programmed limits. It keeps level status for both queues and sticky service, completion and error flags. Software clears the sticky flags by writing ones to them, and any sticky flag that is set holds a level interrupt high.

Top module: `spi_wordpack_fifo`

## Requirements
- R1: After a synchronous active-low reset, the status, flow-error and link-error registers read 0, the config register reads 0, `irq` is low and `eng_tx_avail` is low.
- R2: The config register at offset 0x00 holds bits-per-word minus one in bits [4:0]. A value of 0..7 gives 1 byte per word, 8..15 gives 2 bytes per word, and 16..31 gives 4 bytes per word.
- R3: The transmit word written at offset 0x18 is handed out MSB byte first: bits [31:24], then [23:16], and so on. The word leaves the transmit queue once bytes-per-word bytes have been taken.
- R4: Bytes received are assembled right-justified, with the first byte most significant. With the bytes 12,34,56,78 the word reads 0x12345678 at 4 bytes per word, 0x00001234 at 2 bytes per word and 0x00000012 at 1 byte per word. A word is popped by reading offset 0x1C.
- R5: The status register at offset 0x04 shows four live levels: bit 4 transmit not empty, bit 5 receive not empty, bit 6 transmit full and bit 7 receive full.
- R6: Status bit 8 sets when a transmit word completes and more words are still owed (the write limit is 0 or not yet reached). Status bit 9 sets each time a word enters the receive queue.
- R7: Status bit 10 sets when the count of completed transmit words reaches the nonzero write limit at offset 0x10. Status bit 11 sets when the count of received words reaches the nonzero read limit at offset 0x14. Writing a limit restarts its count.
- R8: Status bits [11:8], flow-error bits [5:2] and link-error bits [1:0] are sticky. Writing a 1 to a bit clears it, and writing a 0 leaves it as it is.
- R9: A bus write to the transmit queue while it is full is dropped, and it sets flow-error bit 5 (offset 0x08).
- R10: A bus read of the receive queue while it is empty returns 0 and sets flow-error bit 4.
- R11: A byte request from the engine while the transmit queue is empty sets flow-error bit 3. A word completed by the engine while the receive queue is full is dropped and sets flow-error bit 2.
- R12: The engine's clock-underrun pulse sets link-error bit 0 and its clock-overrun pulse sets link-error bit 1 (offset 0x0C).
- R13: `irq` is high whenever any sticky status, flow-error or link-error bit is set, and low once all of them are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (pops on the receive data offset) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Level interrupt |
| eng_tx_avail | output | 1 | A transmit byte is available |
| eng_tx_byte | output | 8 | Current transmit byte |
| eng_tx_take | input | 1 | Engine consumes the current transmit byte |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_clk_under | input | 1 | Clock-underrun pulse from the engine |
| eng_clk_over | input | 1 | Clock-overrun pulse from the engine |

## Verification
A wrong byte index in the transmit serializer shows on `eng_tx_byte` at the very next take. It also shows in `eng_tx_avail`, which falls one byte early or late. A wrong receive assembly count shows on the first read of offset 0x1C as a shifted or merged word. Queue pointer or count faults show as a full or empty level that is missing, or that arrives one write too soon. Counter or sticky-flag faults show in the status register and on `irq` one cycle after the word that should have set them.

// File: rtl/spi_wp_pkg.sv
// Package: shared register offsets, field positions and helper functions
// for the SPI word packing FIFO interface.
// Assumes a byte-addressed register bus with 32-bit registers.
package spi_wp_pkg;

    localparam logic [7:0] OFS_CFG    = 8'h00;
    localparam logic [7:0] OFS_STAT   = 8'h04;
    localparam logic [7:0] OFS_FLOW   = 8'h08;
    localparam logic [7:0] OFS_LINK   = 8'h0C;
    localparam logic [7:0] OFS_WRLIM  = 8'h10;
    localparam logic [7:0] OFS_RDLIM  = 8'h14;
    localparam logic [7:0] OFS_TXDATA = 8'h18;
    localparam logic [7:0] OFS_RXDATA = 8'h1C;

    // Index of the last byte in a word (bytes per word minus one),
    // selected by bits-per-word minus one.
    function automatic logic [1:0] last_byte_idx(input logic [4:0] bpw_m1);
        if (bpw_m1 < 5'd8)       return 2'd0;
        else if (bpw_m1 < 5'd16) return 2'd1;
        else                     return 2'd3;
    endfunction

    // Queue depth in words from the block-size code and depth code.
    function automatic int queue_depth(input int blk_code, input int dep_code);
        int blk;
        blk = (blk_code == 0) ? 4 : blk_code * 16;
        return blk * (2 << dep_code);
    endfunction

endpackage

// File: rtl/wp_fifo.sv
// Show-ahead synchronous FIFO of W-bit words.
// The head word is on dout whenever the FIFO is not empty. A push while
// full and a pop while empty are ignored. The caller flags both cases.
module wp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write; no reset is needed on the data array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // A push into a full queue leaves its occupancy untouched.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> $stable(count));

    // A pop from an empty queue leaves it empty.
    p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (count == '0));

endmodule

// File: rtl/wp_tx_serializer.sv
// Splits the head transmit word into bytes, MSB byte first.
// The byte index advances on each take. The word is popped after the
// last byte of the current width. Assumes the width does not change
// in the middle of a word.
module wp_tx_serializer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  last_idx,
    input  logic [31:0] head,
    input  logic        empty,
    input  logic        take,
    output logic [7:0]  byte_o,
    output logic        pop,
    output logic        underrun
);
    logic [1:0] idx;

    assign byte_o   = empty ? 8'h00 : head[{~idx, 3'b000} +: 8];
    assign pop      = take && !empty && (idx == last_idx);
    assign underrun = take && empty;

    // Byte index within the head word.
    always_ff @(posedge clk) begin
        if (!rst_n)                 idx <= 2'd0;
        else if (pop)               idx <= 2'd0;
        else if (take && !empty)    idx <= idx + 2'd1;
    end

endmodule

// File: rtl/wp_rx_assembler.sv
// Gathers received bytes into a right-justified word, first byte highest.
// When the last byte arrives the word is pushed. If the receive queue is
// full, the word is dropped and an overrun pulse is raised.
module wp_rx_assembler (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  last_idx,
    input  logic        valid,
    input  logic [7:0]  byte_i,
    input  logic        full,
    output logic        push,
    output logic [31:0] word,
    output logic        overrun
);
    logic [1:0]  cnt;
    logic [23:0] acc;
    logic        last;

    assign last    = valid && (cnt == last_idx);
    assign word    = {acc, byte_i};
    assign push    = last && !full;
    assign overrun = last && full;

    // Byte count and partial word; both restart after each word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= 2'd0;
            acc <= '0;
        end else if (last) begin
            cnt <= 2'd0;
            acc <= '0;
        end else if (valid) begin
            cnt <= cnt + 2'd1;
            acc <= {acc[15:0], byte_i};
        end
    end

endmodule

// File: rtl/wp_flag_regs.sv
// Word counters plus sticky service, completion and error flags.
// Every flag clears when a 1 is written to it. A set and a clear in the
// same cycle leave the flag set. Writing a limit restarts its counter.
module wp_flag_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_pop,
    input  logic             rx_push,
    input  logic [CNT_W-1:0] wr_lim,
    input  logic [CNT_W-1:0] rd_lim,
    input  logic             wr_lim_we,
    input  logic             rd_lim_we,
    input  logic [3:0]       flow_set,
    input  logic [1:0]       link_set,
    input  logic             stat_we,
    input  logic [3:0]       stat_clr,
    input  logic             flow_we,
    input  logic [3:0]       flow_clr,
    input  logic             link_we,
    input  logic [1:0]       link_clr,
    output logic [3:0]       stat_sticky,
    output logic [3:0]       flow,
    output logic [1:0]       link
);
    logic [CNT_W-1:0] tx_cnt, rx_cnt, tx_next, rx_next;
    logic [3:0]       stat_set;

    assign tx_next = tx_cnt + 1'b1;
    assign rx_next = rx_cnt + 1'b1;

    // Sticky status sources: {in done, out done, in service, out service}.
    always_comb begin
        stat_set[0] = tx_pop && ((wr_lim == '0) || (tx_next < wr_lim));
        stat_set[1] = rx_push;
        stat_set[2] = tx_pop && (wr_lim != '0) && (tx_next == wr_lim);
        stat_set[3] = rx_push && (rd_lim != '0) && (rx_next == rd_lim);
    end

    // Word counters, restarted by a limit write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_cnt <= '0;
            rx_cnt <= '0;
        end else begin
            if (wr_lim_we)    tx_cnt <= '0;
            else if (tx_pop)  tx_cnt <= tx_next;
            if (rd_lim_we)    rx_cnt <= '0;
            else if (rx_push) rx_cnt <= rx_next;
        end
    end

    // Sticky flags with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_sticky <= '0;
            flow        <= '0;
            link        <= '0;
        end else begin
            stat_sticky <= (stat_sticky & ~(stat_we ? stat_clr : 4'h0)) | stat_set;
            flow        <= (flow & ~(flow_we ? flow_clr : 4'h0)) | flow_set;
            link        <= (link & ~(link_we ? link_clr : 2'h0)) | link_set;
        end
    end

    // A completion flag stays set until a write of 1 clears it.
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_sticky[3] && !(stat_we && stat_clr[3])) |=> stat_sticky[3]);

    // A clock-overrun pulse is always recorded.
    p_link_over_r12: assert property (@(posedge clk) disable iff (!rst_n)
        link_set[1] |=> link[1]);

endmodule

// File: rtl/spi_wordpack_fifo.sv
// Top level: register decode, config and limit registers, the two word
// queues, the byte serializer and assembler, and the flag bank.
// Assumes one register access per cycle and a byte-serial shift engine.
module spi_wordpack_fifo
    import spi_wp_pkg::*;
#(
    parameter int BLK_CODE = 0,
    parameter int DEP_CODE = 0,
    parameter int CNT_W    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        eng_tx_avail,
    output logic [7:0]  eng_tx_byte,
    input  logic        eng_tx_take,
    input  logic        eng_rx_valid,
    input  logic [7:0]  eng_rx_byte,
    input  logic        eng_clk_under,
    input  logic        eng_clk_over
);
    localparam int DEPTH = queue_depth(BLK_CODE, DEP_CODE);

    logic [4:0]       cfg_bpw_m1;
    logic [CNT_W-1:0] wr_lim, rd_lim;
    logic [1:0]       last_idx;

    logic             wr_cfg, wr_wrlim, wr_rdlim, wr_tx, rd_rx;
    logic             wr_stat, wr_flow, wr_link;

    logic [31:0]      tx_head, rx_head, rx_word;
    logic             tx_empty, tx_full, rx_empty, rx_full;
    logic             tx_pop, rx_push, tx_under, rx_over;
    logic             in_under, out_over;

    logic [3:0]       stat_sticky, flow;
    logic [1:0]       link;
    logic [31:0]      stat_word;

    // Address decode of the register strobes.
    always_comb begin
        wr_cfg   = bus_we && (bus_addr == OFS_CFG);
        wr_stat  = bus_we && (bus_addr == OFS_STAT);
        wr_flow  = bus_we && (bus_addr == OFS_FLOW);
        wr_link  = bus_we && (bus_addr == OFS_LINK);
        wr_wrlim = bus_we && (bus_addr == OFS_WRLIM);
        wr_rdlim = bus_we && (bus_addr == OFS_RDLIM);
        wr_tx    = bus_we && (bus_addr == OFS_TXDATA);
        rd_rx    = bus_re && (bus_addr == OFS_RXDATA);
    end

    assign last_idx = last_byte_idx(cfg_bpw_m1);
    assign out_over = wr_tx && tx_full;
    assign in_under = rd_rx && rx_empty;

    // Config and limit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_bpw_m1 <= '0;
            wr_lim     <= '0;
            rd_lim     <= '0;
        end else begin
            if (wr_cfg)   cfg_bpw_m1 <= bus_wdata[4:0];
            if (wr_wrlim) wr_lim     <= bus_wdata[CNT_W-1:0];
            if (wr_rdlim) rd_lim     <= bus_wdata[CNT_W-1:0];
        end
    end

    wp_fifo #(.W(32), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(wr_tx), .din(bus_wdata),
        .pop(tx_pop), .dout(tx_head),
        .empty(tx_empty), .full(tx_full)
    );

    wp_fifo #(.W(32), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .din(rx_word),
        .pop(rd_rx), .dout(rx_head),
        .empty(rx_empty), .full(rx_full)
    );

    wp_tx_serializer u_ser (
        .clk(clk), .rst_n(rst_n), .last_idx(last_idx),
        .head(tx_head), .empty(tx_empty), .take(eng_tx_take),
        .byte_o(eng_tx_byte), .pop(tx_pop), .underrun(tx_under)
    );

    wp_rx_assembler u_asm (
        .clk(clk), .rst_n(rst_n), .last_idx(last_idx),
        .valid(eng_rx_valid), .byte_i(eng_rx_byte), .full(rx_full),
        .push(rx_push), .word(rx_word), .overrun(rx_over)
    );

    wp_flag_regs #(.CNT_W(CNT_W)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .tx_pop(tx_pop), .rx_push(rx_push),
        .wr_lim(wr_lim), .rd_lim(rd_lim),
        .wr_lim_we(wr_wrlim), .rd_lim_we(wr_rdlim),
        .flow_set({out_over, in_under, tx_under, rx_over}),
        .link_set({eng_clk_over, eng_clk_under}),
        .stat_we(wr_stat), .stat_clr(bus_wdata[11:8]),
        .flow_we(wr_flow), .flow_clr(bus_wdata[5:2]),
        .link_we(wr_link), .link_clr(bus_wdata[1:0]),
        .stat_sticky(stat_sticky), .flow(flow), .link(link)
    );

    assign stat_word    = {20'h0, stat_sticky, rx_full, tx_full, !rx_empty, !tx_empty, 4'h0};
    assign eng_tx_avail = !tx_empty;
    assign irq          = (|stat_sticky) || (|flow) || (|link);

    // Read data multiplexer.
    always_comb begin
        case (bus_addr)
            OFS_CFG:    bus_rdata = {27'h0, cfg_bpw_m1};
            OFS_STAT:   bus_rdata = stat_word;
            OFS_FLOW:   bus_rdata = {26'h0, flow, 2'b00};
            OFS_LINK:   bus_rdata = {30'h0, link};
            OFS_WRLIM:  bus_rdata = 32'(wr_lim);
            OFS_RDLIM:  bus_rdata = 32'(rd_lim);
            OFS_RXDATA: bus_rdata = rx_empty ? 32'h0 : rx_head;
            default:    bus_rdata = 32'h0;
        endcase
    end

    // A byte request against an empty transmit queue is recorded.
    p_tx_underrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_take && !eng_tx_avail) |=> flow[1]);

    // Any recorded error keeps the interrupt high until it is cleared.
    p_irq_on_error_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (flow != 4'h0) |-> irq);

endmodule

// File: tb/spi_wordpack_fifo_tb.sv
module spi_wordpack_fifo_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, eng_tx_avail;
    logic [7:0]  eng_tx_byte;
    logic        eng_tx_take = 1'b0, eng_rx_valid = 1'b0;
    logic [7:0]  eng_rx_byte = '0;
    logic        eng_clk_under = 1'b0, eng_clk_over = 1'b0;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spi_wordpack_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .eng_tx_avail(eng_tx_avail), .eng_tx_byte(eng_tx_byte),
        .eng_tx_take(eng_tx_take), .eng_rx_valid(eng_rx_valid),
        .eng_rx_byte(eng_rx_byte), .eng_clk_under(eng_clk_under),
        .eng_clk_over(eng_clk_over)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_re = 1'b0;
    endtask

    task automatic take(output logic [7:0] b);
        @(negedge clk);
        eng_tx_take = 1'b1;
        #1 b = eng_tx_byte;
        @(posedge clk); #1;
        eng_tx_take = 1'b0;
    endtask

    task automatic rx(input logic [7:0] b);
        @(negedge clk);
        eng_rx_valid = 1'b1; eng_rx_byte = b;
        @(posedge clk); #1;
        eng_rx_valid = 1'b0;
    endtask

    task automatic clear_all();
        wr(8'h04, 32'hF00);
        wr(8'h08, 32'h3C);
        wr(8'h0C, 32'h3);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h04, v); chk("R1 status", v, 0);
        rd(8'h08, v); chk("R1 flow", v, 0);
        rd(8'h0C, v); chk("R1 link", v, 0);
        rd(8'h00, v); chk("R1 cfg", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 avail", eng_tx_avail, 0);
    endtask

    task automatic t_tx_wide();
        logic [31:0] v; logic [7:0] b;
        logic [7:0] exp [8] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'h11, 8'h22, 8'h33, 8'h44};
        wr(8'h00, 31); wr(8'h10, 2);
        wr(8'h18, 32'hA1B2C3D4); wr(8'h18, 32'h11223344);
        rd(8'h04, v); chk("R5 tx not empty", v, 32'h010);
        for (int i = 0; i < 4; i++) begin take(b); chk("R3 byte order", b, exp[i]); end
        rd(8'h04, v); chk("R6 out service", v, 32'h110);
        for (int i = 4; i < 8; i++) begin take(b); chk("R3 byte order", b, exp[i]); end
        rd(8'h04, v); chk("R7 out done", v, 32'h500);
        chk("R13 irq set", irq, 1);
        wr(8'h04, 32'hF00);
        rd(8'h04, v); chk("R8 status cleared", v, 0);
        chk("R13 irq clear", irq, 0);
    endtask

    task automatic t_tx_narrow();
        logic [7:0] b;
        wr(8'h10, 0); wr(8'h00, 7);
        wr(8'h18, 32'hC3FFFFFF);
        take(b); chk("R2 1-byte value", b, 8'hC3);
        chk("R2 1-byte pop", eng_tx_avail, 0);
        wr(8'h00, 15);
        wr(8'h18, 32'hBEEF1234);
        take(b); chk("R2 2-byte first", b, 8'hBE);
        chk("R2 2-byte still held", eng_tx_avail, 1);
        take(b); chk("R2 2-byte second", b, 8'hEF);
        chk("R2 2-byte pop", eng_tx_avail, 0);
        clear_all();
    endtask

    task automatic t_rx();
        logic [31:0] v;
        wr(8'h00, 31); wr(8'h14, 2);
        rx(8'h12); rx(8'h34); rx(8'h56); rx(8'h78);
        rd(8'h04, v); chk("R6 in service, R5 rx not empty", v, 32'h220);
        rd(8'h1C, v); chk("R4 4-byte word", v, 32'h12345678);
        wr(8'h00, 15);
        rx(8'h12); rx(8'h34);
        rd(8'h04, v); chk("R7 in done", v[11:8], 4'hA);
        rd(8'h1C, v); chk("R4 2-byte word", v, 32'h00001234);
        wr(8'h00, 7);
        rx(8'h12);
        rd(8'h1C, v); chk("R4 1-byte word", v, 32'h00000012);
        wr(8'h04, 32'h200);
        rd(8'h04, v); chk("R8 partial clear", v, 32'h800);
        clear_all();
    endtask

    task automatic t_tx_overrun();
        logic [31:0] v; logic [7:0] b;
        wr(8'h00, 7);
        for (int i = 0; i < 8; i++) wr(8'h18, {8'(i), 24'h0});
        rd(8'h04, v); chk("R5 tx full", v[7:4], 4'h5);
        wr(8'h18, 32'hDEADBEEF);
        rd(8'h08, v); chk("R9 out overrun", v, 32'h20);
        for (int i = 0; i < 8; i++) begin take(b); chk("R9 contents kept", b, 8'(i)); end
        chk("R9 dropped word", eng_tx_avail, 0);
        take(b);
        rd(8'h08, v); chk("R11 out underrun", v, 32'h28);
        clear_all();
    endtask

    task automatic t_rx_overrun();
        logic [31:0] v;
        wr(8'h00, 7); wr(8'h14, 0);
        for (int i = 0; i < 8; i++) rx(8'h40 + 8'(i));
        rd(8'h04, v); chk("R5 rx full", v[7:4], 4'hA);
        rx(8'hEE);
        rd(8'h08, v); chk("R11 in overrun", v, 32'h04);
        for (int i = 0; i < 8; i++) begin rd(8'h1C, v); chk("R11 kept words", v, 32'h40 + i); end
        rd(8'h04, v); chk("R11 word dropped", v[5], 0);
        rd(8'h1C, v); chk("R10 empty read value", v, 0);
        rd(8'h08, v); chk("R10 in underrun", v, 32'h14);
        clear_all();
    endtask

    task automatic t_link();
        logic [31:0] v;
        @(negedge clk); eng_clk_under = 1'b1; @(posedge clk); #1 eng_clk_under = 1'b0;
        rd(8'h0C, v); chk("R12 clock underrun", v, 1);
        @(negedge clk); eng_clk_over = 1'b1; @(posedge clk); #1 eng_clk_over = 1'b0;
        rd(8'h0C, v); chk("R12 clock overrun", v, 3);
        chk("R13 irq link", irq, 1);
        wr(8'h0C, 1);
        rd(8'h0C, v); chk("R8 link partial clear", v, 2);
        clear_all();
        chk("R13 irq idle", irq, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_tx_wide();
        t_tx_narrow();
        t_rx();
        t_tx_overrun();
        t_rx_overrun();
        t_link();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule